// File: doc/BRIEF.md
# Transmit Cell Buffer with Byte Unpacker

This block sits between a cell builder and a byte-wide PHY transmit port, in one clock domain. The builder writes cells as 32-bit words: one header word (four header bytes, no HEC) followed by twelve payload words, thirteen words in all. The buffer holds up to eight such cells in fixed slots. A slot is reserved when the first word of a cell is accepted. The cell becomes visible to the read side only once its thirteenth word has been stored.

The PHY side pulls one byte per cycle in which it raises `phy_ready`. Each stored word is sent as four bytes, most significant byte first, and the first byte of every cell is marked with `tx_soc`. When a cell boundary is reached and no complete user cell is waiting, the block sends an idle cell instead. The idle cell has header bytes 00 00 00 01 and 48 payload bytes of 0x6A, so the PHY always has a byte to take. Cells leave in the order they were committed.

Top module: `txcell_unpacker`

## Requirements
- R1: After reset the buffer is empty: `buf_full`=0, `wr_ready`=1, `tx_soc`=1, `tx_idle`=1 and `tx_byte`=0x00, which is the first byte of an idle cell.
- R2: An idle cell is 52 bytes: 0x00, 0x00, 0x00, 0x01, then 48 bytes of 0x6A. `tx_idle` is 1 on its first byte.
- R3: The buffer holds at most 8 cells. With 8 cells committed, `buf_full`=1 and `wr_ready`=0, and a word offered then is dropped and never transmitted.
- R4: A cell is sent only after all 13 of its words are written. A cell boundary that falls while the cell is incomplete produces an idle cell.
- R5: Each 32-bit word goes out as four bytes, bits 31:24 first and bits 7:0 last. Each cell is 52 bytes.
- R6: `tx_soc` is 1 exactly on the first byte of each cell and 0 on the other 51 bytes.
- R7: User cells are sent whole, in commit order, across the wrap of the slot ring. `tx_idle`=0 on the first byte of a user cell.
- R8: A slot is freed in the cycle after the last byte of its cell is taken, so `buf_full` drops then.
- R9: Once the first word of a cell is accepted, `wr_ready` stays 1 until the cell's 13th word is written, even if `buf_full` is 1 meanwhile.
- R10: Within a cell, when `phy_ready` is 0 the byte on `tx_byte` is held and no byte is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A word is offered on `wr_data` |
| wr_data | input | 32 | Cell word (header word first, then payload words) |
| wr_ready | output | 1 | The offered word is accepted this cycle |
| buf_full | output | 1 | No free slot for a new cell |
| phy_ready | input | 1 | The PHY takes `tx_byte` this cycle |
| tx_byte | output | 8 | Current transmit byte |
| tx_soc | output | 1 | `tx_byte` is the first byte of a cell |
| tx_idle | output | 1 | The current cell is an idle cell |

## Verification
The bench checks the boundary decision from both sides. A cell twelve words long must still produce an idle cell, and a cell written while an idle cell is being sent must follow it directly; a design that commits early would send stale or partial words. It fills all eight slots, checks that full is raised while the eighth cell is still incomplete without blocking that cell, and offers a word while full. A design that lets the word in would corrupt slot order or send a ninth cell. It also checks that the slot frees in the cycle after the last byte, that a stall in mid-cell holds the byte, and that the whole stream stays in order over several wraps of the slot ring.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
  localparam logic [WORD_W-1:0] IDLE_HDR = 32'h0000_0001;
  localparam logic [BYTE_W-1:0] IDLE_FILL = 8'h6A;

  // Byte idx of a word, idx 0 being the most significant byte.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input int unsigned idx);
    int unsigned top;
    top = (WORD_W - 1) - BYTE_W * idx;
    return w[top -: BYTE_W];
  endfunction

  // Word widx of the idle cell.
  function automatic logic [WORD_W-1:0] idle_word(input int unsigned widx);
    return (widx == 0) ? IDLE_HDR : {BYTES_PER_WORD{IDLE_FILL}};
  endfunction

  // Next slot on the ring.
  function automatic int unsigned next_slot(input int unsigned s, input int unsigned n);
    return (s == n - 1) ? 0 : s + 1;
  endfunction
endpackage

// File: rtl/txc_slot_ctrl.sv
module txc_slot_ctrl
  import txc_pkg::*;
#(
  parameter int NUM_CELLS      = 8,
  parameter int WORDS_PER_CELL = 13,
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int WIDX_W = $clog2(WORDS_PER_CELL),
  localparam int CNT_W  = $clog2(NUM_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              rel_cell,
  output logic              wr_ready,
  output logic              buf_full,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [WIDX_W-1:0] wr_word,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              cell_avail
);
  logic [CNT_W-1:0] cnt_commit;
  logic [CNT_W:0]   reserved;
  logic             in_cell;
  logic             commit_cell;

  assign in_cell     = (wr_word != '0);
  assign reserved    = {1'b0, cnt_commit} + {{CNT_W{1'b0}}, in_cell};
  assign buf_full    = (reserved == (CNT_W+1)'(NUM_CELLS));
  assign wr_ready    = in_cell || !buf_full;
  assign wr_en       = wr_valid && wr_ready;
  assign commit_cell = wr_en && (wr_word == WIDX_W'(WORDS_PER_CELL - 1));
  assign cell_avail  = (cnt_commit != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot    <= '0;
      wr_word    <= '0;
      rd_slot    <= '0;
      cnt_commit <= '0;
    end else begin
      if (wr_en) begin
        if (commit_cell) begin
          wr_word <= '0;
          wr_slot <= SLOT_W'(next_slot(int'(wr_slot), NUM_CELLS));
        end else begin
          wr_word <= wr_word + 1'b1;
        end
      end
      if (rel_cell)
        rd_slot <= SLOT_W'(next_slot(int'(rd_slot), NUM_CELLS));
      case ({commit_cell, rel_cell})
        2'b10:   cnt_commit <= cnt_commit + 1'b1;
        2'b01:   cnt_commit <= cnt_commit - 1'b1;
        default: cnt_commit <= cnt_commit;
      endcase
    end
  end

  // R3: reservations never exceed the slot count
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    reserved <= (CNT_W+1)'(NUM_CELLS));
  // R9: a started cell can always be completed
  a_r9_cell_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word != '0) |-> wr_ready);
  // R7: only committed cells are released
  a_r7_release_committed: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cell |-> (cnt_commit != '0));
  // R8: a release with no commit frees one slot
  a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_cell && !commit_cell) |=> (cnt_commit == $past(cnt_commit) - 1'b1));
endmodule

// File: rtl/txc_store.sv
module txc_store
  import txc_pkg::*;
#(
  parameter int DEPTH = 104,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txc_unpack.sv
module txc_unpack
  import txc_pkg::*;
#(
  parameter int WORDS_PER_CELL = 13,
  localparam int WIDX_W = $clog2(WORDS_PER_CELL),
  localparam int BIDX_W = $clog2(BYTES_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_ready,
  input  logic              cell_avail,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WIDX_W-1:0] rd_word,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_soc,
  output logic              tx_idle,
  output logic              rel_cell
);
  logic [BIDX_W-1:0] bidx;
  logic              cur_idle;
  logic              at_start;
  logic              last_byte;
  logic              sel_idle;
  logic [WORD_W-1:0] cur_word;

  assign at_start  = (rd_word == '0) && (bidx == '0);
  assign last_byte = (rd_word == WIDX_W'(WORDS_PER_CELL - 1)) &&
                     (bidx == BIDX_W'(BYTES_PER_WORD - 1));
  // The choice between user and idle cell is open only on the first byte.
  assign sel_idle  = at_start ? !cell_avail : cur_idle;
  assign cur_word  = sel_idle ? idle_word(int'(rd_word)) : rd_data;
  assign tx_byte   = pick_byte(cur_word, int'(bidx));
  assign tx_soc    = at_start;
  assign tx_idle   = sel_idle;
  assign rel_cell  = phy_ready && last_byte && !sel_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_word  <= '0;
      bidx     <= '0;
      cur_idle <= 1'b1;
    end else if (phy_ready) begin
      if (at_start) cur_idle <= sel_idle;
      if (bidx == BIDX_W'(BYTES_PER_WORD - 1)) begin
        bidx    <= '0;
        rd_word <= last_byte ? '0 : rd_word + 1'b1;
      end else begin
        bidx <= bidx + 1'b1;
      end
    end
  end

  // R6: a start-of-cell byte that is taken is followed by a non-start byte
  a_r6_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ready && tx_soc) |=> !tx_soc);
  // R10: a stall inside a cell holds the byte
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_ready && !at_start) |=> ($stable(tx_byte) && $stable(tx_idle)));
  // R5: the byte position advances only when a byte is taken
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_ready |=> ($stable(bidx) && $stable(rd_word)));
endmodule

// File: rtl/txcell_unpacker.sv
module txcell_unpacker
  import txc_pkg::*;
#(
  parameter int NUM_CELLS      = 8,
  parameter int WORDS_PER_CELL = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  output logic        buf_full,
  input  logic        phy_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_soc,
  output logic        tx_idle
);
  localparam int DEPTH  = NUM_CELLS * WORDS_PER_CELL;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;
  localparam int WIDX_W = $clog2(WORDS_PER_CELL);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [SLOT_W-1:0] s,
                                                  input logic [WIDX_W-1:0] w);
    return ADDR_W'(int'(s) * WORDS_PER_CELL + int'(w));
  endfunction

  logic              wr_en;
  logic              rel_cell;
  logic              cell_avail;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic [WIDX_W-1:0] wr_word;
  logic [WIDX_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_data;

  txc_slot_ctrl #(.NUM_CELLS(NUM_CELLS), .WORDS_PER_CELL(WORDS_PER_CELL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rel_cell(rel_cell),
    .wr_ready(wr_ready), .buf_full(buf_full), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_word(wr_word), .rd_slot(rd_slot),
    .cell_avail(cell_avail)
  );

  txc_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(word_addr(wr_slot, wr_word)),
    .wr_data(wr_data), .rd_addr(word_addr(rd_slot, rd_word)), .rd_data(rd_data)
  );

  txc_unpack #(.WORDS_PER_CELL(WORDS_PER_CELL)) u_unpack (
    .clk(clk), .rst_n(rst_n), .phy_ready(phy_ready), .cell_avail(cell_avail),
    .rd_data(rd_data), .rd_word(rd_word), .tx_byte(tx_byte), .tx_soc(tx_soc),
    .tx_idle(tx_idle), .rel_cell(rel_cell)
  );

  // R4: a user cell starts only when a committed cell exists
  a_r4_user_committed: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_soc && !tx_idle) |-> cell_avail);
  // R3: nothing is accepted while full outside a started cell
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && wr_word == '0) |-> !wr_en);
endmodule

// File: tb/txcell_unpacker_bench.sv
`timescale 1ns/1ps
module txcell_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        phy_ready = 1'b0;
  logic        wr_ready, buf_full, tx_soc, tx_idle;
  logic [7:0]  tx_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] got [52];
  logic       gsoc [52];
  logic       gidle;

  txcell_unpacker u_txcell_unpacker (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .buf_full(buf_full), .phy_ready(phy_ready),
    .tx_byte(tx_byte), .tx_soc(tx_soc), .tx_idle(tx_idle)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] mkword(input int c, input int k);
    return {8'(c), 8'(k), 8'(c) ^ 8'(k) ^ 8'h5A, 8'hC0 + 8'(k)};
  endfunction

  function automatic logic [7:0] exp_byte(input bit idle, input int c, input int j);
    logic [31:0] w;
    int k, b;
    k = j / 4;
    b = j % 4;
    if (idle) begin
      if (k == 0) return (b == 3) ? 8'h01 : 8'h00;
      return 8'h6A;
    end
    w = mkword(c, k);
    return 8'(w >> (8 * (3 - b)));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_words(input int c, input int from, input int to);
    for (int k = from; k < to; k++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data = mkword(c, k);
      phy_ready = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Take bytes from..to-1; optionally write cell wc in the first 13 cycles.
  task automatic take(input int from, input int to, input int wc);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      phy_ready = 1'b1;
      if (wc >= 0 && (i - from) < 13) begin
        wr_valid = 1'b1;
        wr_data = mkword(wc, i - from);
      end else begin
        wr_valid = 1'b0;
      end
      got[i] = tx_byte;
      gsoc[i] = tx_soc;
      if (i == 0) gidle = tx_idle;
      @(posedge clk);
    end
    @(negedge clk);
    phy_ready = 1'b0;
    wr_valid = 1'b0;
  endtask

  task automatic check_cell(input bit idle, input int c, input string req);
    int bad, fa, fe;
    bad = 0; fa = 0; fe = 0;
    for (int j = 0; j < 52; j++) begin
      if (got[j] !== exp_byte(idle, c, j)) begin
        if (bad == 0) begin fa = got[j]; fe = exp_byte(idle, c, j); end
        bad++;
      end
      if (gsoc[j] !== (j == 0)) begin
        if (bad == 0) begin fa = 32'h50C; fe = j; end
        bad++;
      end
    end
    if (gidle !== idle) begin
      if (bad == 0) begin fa = gidle; fe = idle; end
      bad++;
    end
    chk(bad == 0, req, $sformatf("cell %0d idle=%0d", c, idle), fa, fe);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(buf_full === 1'b0 && wr_ready === 1'b1, "R1", "flags", {buf_full, wr_ready}, 2'b01);
    chk(tx_soc === 1'b1 && tx_idle === 1'b1 && tx_byte === 8'h00, "R1", "first byte",
        {tx_soc, tx_idle, tx_byte}, 10'h300);

    // R2, R6: idle cell with nothing stored
    take(0, 52, -1);
    check_cell(1, 0, "R2");

    // R4: 12 words are not enough for a cell
    put_words(0, 0, 12);
    chk(wr_ready === 1'b1, "R4", "wr_ready mid-cell", wr_ready, 1);
    take(0, 52, -1);
    check_cell(1, 0, "R4");
    put_words(0, 12, 13);
    take(0, 52, -1);
    check_cell(0, 0, "R5");

    // R3, R9: fill all eight slots
    for (int c = 1; c <= 7; c++) put_words(c, 0, 13);
    chk(buf_full === 1'b0, "R3", "seven cells not full", buf_full, 0);
    put_words(8, 0, 1);
    chk(buf_full === 1'b1 && wr_ready === 1'b1, "R9", "eighth cell started",
        {buf_full, wr_ready}, 2'b11);
    put_words(8, 1, 13);
    chk(buf_full === 1'b1 && wr_ready === 1'b0, "R3", "eight cells full",
        {buf_full, wr_ready}, 2'b10);
    put_words(99, 0, 1);  // must be dropped
    chk(buf_full === 1'b1, "R3", "still full after dropped word", buf_full, 1);

    // R8: slot freed right after the last byte
    take(0, 52, -1);
    check_cell(0, 1, "R7");
    chk(buf_full === 1'b0, "R8", "full after release", buf_full, 0);
    for (int c = 2; c <= 8; c++) begin
      take(0, 52, -1);
      check_cell(0, c, "R7");
    end
    take(0, 52, -1);
    check_cell(1, 0, "R3");

    // R10: a mid-cell stall holds the byte
    put_words(10, 0, 13);
    take(0, 6, -1);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk(tx_byte === exp_byte(0, 10, 6) && tx_soc === 1'b0, "R10", "held byte",
          tx_byte, exp_byte(0, 10, 6));
    end
    take(6, 52, -1);
    check_cell(0, 10, "R10");

    // R4: cell written during an idle cell follows it
    take(0, 52, 40);
    check_cell(1, 0, "R4");
    take(0, 52, -1);
    check_cell(0, 40, "R4");

    // R7: streaming across several ring wraps
    for (int c = 20; c < 40; c++) begin
      put_words(c, 0, 13);
      put_words(c + 100, 0, 13);
      take(0, 52, -1);
      check_cell(0, c, "R7");
      take(0, 52, -1);
      check_cell(0, c + 100, "R7");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule